// File: doc/BRIEF.md
# Dual-Width Packed-Opcode ALU

This execution unit performs one arithmetic or logic operation for each request it accepts. A single 8-bit opcode carries three fields. The top four bits name the operation. One bit picks the second operand, either the 32-bit immediate or the source register value. The low three bits give the class, which chooses 32-bit or 64-bit operation. The destination register value is always the first operand.

The block takes a request in one cycle and registers the result. In the following cycle it presents the 64-bit result with a valid strobe and an illegal-operation flag. Results computed at 32-bit width are zero-extended. An operation the unit does not support returns the destination value untouched and raises the illegal flag. The register file, program sequencing and memory access are handled outside the block.

Top module: `pk_alu_top`

## Requirements
- R1: The result, its valid strobe and its illegal flag appear on the clock edge after a request is accepted. The valid strobe is low in every cycle that does not follow a request, and the illegal flag is low whenever the valid strobe is low.
- R2: Opcode bits [2:0] select the class: 3'b100 gives 32-bit operation and 3'b111 gives 64-bit operation. Opcode bit 3 picks the second operand: 0 selects the immediate and 1 selects the source register.
- R3: Operation field opcode[7:4] uses these codes: 0x0 add, 0x1 subtract (destination minus operand), 0x2 multiply (low bits of the product), 0x4 or, 0x5 and, 0xa xor, 0xb move (the result is the operand).
- R4: In 32-bit operation, both operands are cut to their low 32 bits before the operation, and the result is zero-extended to 64 bits.
- R5: In 64-bit operation, the 32-bit immediate is sign-extended to 64 bits before use.
- R6: Code 0x6 shifts left, code 0x7 shifts right logically and code 0xc shifts right arithmetically. The shift amount is the operand masked to 5 bits in 32-bit operation and to 6 bits in 64-bit operation.
- R7: Code 0x8 returns the two's-complement negation of the destination at the class width. The second operand has no effect on the result.
- R8: Code 0x3 is an unsigned divide. A divisor of zero gives a result of 0.
- R9: Code 0x9 is an unsigned remainder. A divisor of zero returns the destination, cut to 32 bits in 32-bit operation.
- R10: Code 0xd reverses the byte order of the low 16, 32 or 64 bits of the full destination value, as chosen by an immediate of 16, 32 or 64. The result is zero-extended, and class width and bit 3 have no effect. Any other immediate value is illegal.
- R11: Operation codes 0xe and 0xf, any class other than the two arithmetic classes, and a byte-order operation with an unsupported immediate all raise the illegal flag and return the full 64-bit destination unchanged.
- R12: While reset is asserted, the valid strobe and the illegal flag are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Packed opcode: operation, operand select, class |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate |
| res_valid_o | output | 1 | Result valid, one cycle after a request |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Unsupported operation flag |

## Verification
Every result, its valid strobe and its illegal flag come from one register stage, so they are due exactly one rising edge after the request is presented. The bench drives a request on a falling edge and compares all three outputs at the next falling edge, which lies half a period after the capturing edge. It then drops the request for one cycle and checks that the valid strobe has fallen. This confirms that no output stays asserted beyond its single due cycle.

// File: rtl/pk_alu_pkg.sv
package pk_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3,
    OP_OR  = 4'h4, OP_AND = 4'h5, OP_SHL = 4'h6, OP_SHR = 4'h7,
    OP_NEG = 4'h8, OP_MOD = 4'h9, OP_XOR = 4'ha, OP_MOV = 4'hb,
    OP_SAR = 4'hc, OP_BSW = 4'hd, OP_RE0 = 4'he, OP_RE1 = 4'hf
  } alu_op_e;

  localparam logic [2:0] CLS_W32 = 3'b100;
  localparam logic [2:0] CLS_W64 = 3'b111;

  typedef struct packed {
    logic    legal;
    logic    w64;
    logic    use_reg;
    alu_op_e op;
  } alu_dec_t;
endpackage

// File: rtl/pk_alu_dec.sv
module pk_alu_dec
  import pk_alu_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int IMM_W = 32
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [IMM_W-1:0] imm_i,
  output alu_dec_t         dec_o
);
  logic [2:0] cls;
  logic       cls_ok;
  logic       bsw_ok;

  assign cls    = opcode_i[2:0];
  assign cls_ok = (cls == CLS_W32) || (cls == CLS_W64);
  assign bsw_ok = (imm_i == IMM_W'(16)) || (imm_i == IMM_W'(32)) ||
                  (imm_i == IMM_W'(64));

  always_comb begin
    dec_o.op      = alu_op_e'(opcode_i[7:4]);
    dec_o.use_reg = opcode_i[3];
    dec_o.w64     = (cls == CLS_W64);
    dec_o.legal   = cls_ok;
    if (dec_o.op == OP_RE0 || dec_o.op == OP_RE1) dec_o.legal = 1'b0;
    if (dec_o.op == OP_BSW && !bsw_ok)             dec_o.legal = 1'b0;
  end
endmodule

// File: rtl/pk_alu_opnd.sv
module pk_alu_opnd
  import pk_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  alu_dec_t          dec_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] b_raw;

  assign imm_sx = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign b_raw  = dec_i.use_reg ? src_i : imm_sx;

  // narrow class sees only the low half of each operand
  assign a_o = dec_i.w64 ? dst_i : {{HALF_W{1'b0}}, dst_i[HALF_W-1:0]};
  assign b_o = dec_i.w64 ? b_raw : {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
endmodule

// File: rtl/pk_alu_core.sv
module pk_alu_core
  import pk_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  alu_dec_t          dec_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              illegal_o
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int SH_W    = $clog2(DATA_W);
  localparam int NBYTES  = DATA_W / 8;

  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] sar_w;
  logic [HALF_W-1:0] sar_n;
  logic [DATA_W-1:0] swp16, swp32, swp64, swp;

  assign sh    = dec_i.w64 ? b_i[SH_W-1:0] : {1'b0, b_i[SH_W-2:0]};
  assign sar_w = DATA_W'($signed(a_i) >>> sh);
  assign sar_n = HALF_W'($signed(a_i[HALF_W-1:0]) >>> sh);

  // byte-order reversal of 2, 4 and 8 byte spans
  always_comb begin
    swp16 = '0;
    swp32 = '0;
    swp64 = '0;
    for (int i = 0; i < 2; i++)      swp16[8*i +: 8] = dst_i[8*(1-i) +: 8];
    for (int i = 0; i < 4; i++)      swp32[8*i +: 8] = dst_i[8*(3-i) +: 8];
    for (int i = 0; i < NBYTES; i++) swp64[8*i +: 8] = dst_i[8*(NBYTES-1-i) +: 8];
    case (imm_i[6:4])
      3'b001:  swp = swp16;
      3'b010:  swp = swp32;
      default: swp = swp64;
    endcase
  end

  always_comb begin
    unique case (dec_i.op)
      OP_ADD:  raw = a_i + b_i;
      OP_SUB:  raw = a_i - b_i;
      OP_MUL:  raw = a_i * b_i;
      OP_DIV:  raw = (b_i == '0) ? '0 : a_i / b_i;
      OP_OR:   raw = a_i | b_i;
      OP_AND:  raw = a_i & b_i;
      OP_SHL:  raw = a_i << sh;
      OP_SHR:  raw = a_i >> sh;
      OP_NEG:  raw = '0 - a_i;
      OP_MOD:  raw = (b_i == '0) ? a_i : a_i % b_i;
      OP_XOR:  raw = a_i ^ b_i;
      OP_MOV:  raw = b_i;
      OP_SAR:  raw = dec_i.w64 ? sar_w : {{HALF_W{1'b0}}, sar_n};
      default: raw = dst_i;
    endcase
  end

  always_comb begin
    illegal_o = !dec_i.legal;
    if (!dec_i.legal)            res_o = dst_i;
    else if (dec_i.op == OP_BSW) res_o = swp;
    else if (dec_i.w64)          res_o = raw;
    else                         res_o = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/pk_alu_top.sv
module pk_alu_top
  import pk_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OPC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  alu_dec_t          dec;
  logic [DATA_W-1:0] a, b, res;
  logic              ill;

  pk_alu_dec #(.OPC_W(OPC_W), .IMM_W(IMM_W)) u_dec (
    .opcode_i (opcode_i),
    .imm_i    (imm_i),
    .dec_o    (dec)
  );

  pk_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .dec_i (dec),
    .dst_i (dst_i),
    .src_i (src_i),
    .imm_i (imm_i),
    .a_o   (a),
    .b_o   (b)
  );

  pk_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .dec_i     (dec),
    .a_i       (a),
    .b_i       (b),
    .dst_i     (dst_i),
    .imm_i     (imm_i),
    .res_o     (res),
    .illegal_o (ill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      result_o    <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      illegal_o   <= req_valid_i & ill;
      if (req_valid_i) result_o <= res;
    end
  end
endmodule

// File: rtl/pk_alu_chk.sv
module pk_alu_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OPC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o); // R1
  AST_ILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !illegal_o); // R1
  AST_W32_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && opcode_i[2:0] == 3'b100 && opcode_i[7:4] < 4'hd
    |=> result_o[DATA_W-1:DATA_W/2] == '0); // R4
  AST_IMM_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && opcode_i == 8'hb7
    |=> result_o == {{(DATA_W-IMM_W){$past(imm_i[IMM_W-1])}}, $past(imm_i)}); // R5
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && opcode_i == 8'h3f && src_i == '0 |=> result_o == '0); // R8
  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && opcode_i[7:5] == 3'b111
    |=> illegal_o && result_o == $past(dst_i)); // R11
endmodule

bind pk_alu_top pk_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/pk_alu_top_tb.sv
module pk_alu_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [31:0] imm_i = '0;
  logic        res_valid_o, illegal_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  pk_alu_top u_dut (.*);

  function automatic logic [64:0] ref_model(logic [7:0] opc, logic [63:0] d,
                                            logic [63:0] s, logic [31:0] im);
    logic [63:0] x, y, r, m;
    logic        wide;
    int          amt;
    if ((opc[2:0] != 3'd4 && opc[2:0] != 3'd7) || opc[7:4] >= 4'he)
      return {1'b1, d};
    if (opc[7:4] == 4'hd) begin
      int nb;
      if (im == 32'd16) nb = 2; else if (im == 32'd32) nb = 4;
      else if (im == 32'd64) nb = 8; else return {1'b1, d};
      r = '0;
      for (int k = 0; k < nb; k++) r[8*k +: 8] = d[8*(nb-1-k) +: 8];
      return {1'b0, r};
    end
    wide = (opc[2:0] == 3'd7);
    m = wide ? '1 : 64'h0000_0000_ffff_ffff;
    x = d & m;
    y = (opc[3] ? s : {{32{im[31]}}, im}) & m;
    amt = wide ? int'(y[5:0]) : int'(y[4:0]);
    case (opc[7:4])
      4'h0: r = x + y;
      4'h1: r = x - y;
      4'h2: r = x * y;
      4'h3: r = (y == 0) ? 64'd0 : x / y;
      4'h4: r = x | y;
      4'h5: r = x & y;
      4'h6: r = x << amt;
      4'h7: r = x >> amt;
      4'h8: r = -x;
      4'h9: r = (y == 0) ? x : x % y;
      4'ha: r = x ^ y;
      4'hb: r = y;
      default: begin
        r = x;
        for (int k = 0; k < amt; k++)
          r = wide ? {r[63], r[63:1]} : {32'd0, r[31], r[31:1]};
      end
    endcase
    return {1'b0, r & m};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [7:0] opc, logic [63:0] d,
                     logic [63:0] s, logic [31:0] im);
    logic [64:0] e;
    e = ref_model(opc, d, s, im);
    @(negedge clk_i);
    req_valid_i = 1'b1; opcode_i = opc; dst_i = d; src_i = s; imm_i = im;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({req, " R1 valid"}, {63'd0, res_valid_o}, 64'd1);
    check({req, " illegal"}, {63'd0, illegal_o}, {63'd0, e[64]});
    check({req, " result"}, result_o, e[63:0]);
    @(negedge clk_i);
    check("R1 valid drop", {63'd0, res_valid_o}, 64'd0);
    check("R1 illegal quiet", {63'd0, illegal_o}, 64'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] big;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    check("R12 valid", {63'd0, res_valid_o}, 64'd0);
    check("R12 illegal", {63'd0, illegal_o}, 64'd0);
    check("R12 result", result_o, 64'd0);
    rst_ni = 1'b1;
    big = 64'hf123_4567_89ab_cdef;
    run("R3 add64 reg", 8'h0f, 64'd5, 64'd7, 32'd0);
    run("R4 add32 wrap", 8'h0c, 64'hffff_ffff_ffff_ffff, 64'h1, 32'd0);
    run("R5 mov64 imm neg", 8'hb7, big, 64'd0, 32'h8000_0001);
    run("R4 mov32 imm neg", 8'hb4, big, 64'd0, 32'h8000_0001);
    run("R3 sub64", 8'h1f, 64'd3, 64'd5, 32'd0);
    run("R3 mul32", 8'h2c, 64'h1_0000_0003, 64'h5_0000_0004, 32'd0);
    run("R6 shl32 mask", 8'h64, 64'h1, 64'd0, 32'd33);
    run("R6 shl64 mask", 8'h67, 64'h1, 64'd0, 32'd65);
    run("R6 sar32", 8'hc4, 64'h0000_0000_8000_0000, 64'd0, 32'd4);
    run("R6 sar64", 8'hcf, big, 64'd12, 32'd0);
    run("R6 shr64", 8'h7f, big, 64'd60, 32'd0);
    run("R7 neg64", 8'h87, 64'd1, 64'd9, 32'd7);
    run("R7 neg32", 8'h8c, 64'hffff_0000_0000_0002, 64'd9, 32'd7);
    run("R8 div0", 8'h3f, big, 64'd0, 32'd0);
    run("R8 div32", 8'h3c, 64'hffff_ffff_0000_0064, 64'h7, 32'd0);
    run("R9 mod0 64", 8'h9f, big, 64'd0, 32'd0);
    run("R9 mod0 32", 8'h9c, big, 64'd0, 32'd0);
    run("R9 mod64", 8'h9f, 64'd100, 64'd7, 32'd0);
    run("R10 swap16", 8'hd4, big, 64'd0, 32'd16);
    run("R10 swap32", 8'hdc, big, 64'd0, 32'd32);
    run("R10 swap64", 8'hd4, big, 64'd0, 32'd64);
    run("R10 swap bad imm", 8'hd7, big, 64'd0, 32'd8);
    run("R11 op e", 8'he7, big, 64'd1, 32'd1);
    run("R11 op f", 8'hfc, big, 64'd1, 32'd1);
    run("R11 bad class", 8'h05, big, 64'd1, 32'd1);
    run("R2 imm vs reg", 8'h47, 64'h10, 64'h1, 32'h2);
    run("R3 xor32", 8'hac, big, 64'hffff_ffff_ffff_ffff, 32'd0);
    run("R3 and64 imm", 8'h57, big, 64'd0, 32'hffff_0000);
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  opc;
      logic [63:0] d, s;
      logic [31:0] im;
      opc = {4'($urandom_range(0, 15)), 1'($urandom),
             ($urandom_range(0, 9) == 0) ? 3'($urandom) : (($urandom & 1) ? 3'd7 : 3'd4)};
      d = {$urandom, $urandom};
      s = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
      im = $urandom;
      if (opc[7:4] == 4'hd) im = ($urandom_range(0, 3) == 0) ? 32'd24 : 32'(16 << $urandom_range(0, 2));
      run("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", opc, d, s, im);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule